// File: doc/BRIEF.md
# Accumulator Arithmetic and Status Word Unit

This block forms the sum or difference of an 8-bit accumulator value and an 8-bit operand, with or without the stored carry. It keeps a status byte that holds the carry, nibble carry and signed overflow of the most recent arithmetic operation. The byte also holds two general user bits and a pair of bank-select bits. Bit 0 of the status byte shows the live parity of the accumulator. The unit also turns a 3-bit working-register index into a 5-bit internal RAM address, placing the register in one of four banks of eight.

The arithmetic result is combinational and is valid in the same cycle as the operation code. On the next rising clock edge, the flags of that operation load into the status register. A status write port loads the whole byte except the parity bit. Dedicated operation codes set or clear the carry alone.

Top module: `psw_alu_core`

## Requirements
- R1: `result_o` is combinational in the cycle the operation is presented. Op codes: 1 = ADD gives (A+B) mod 256. 2 = ADDC gives (A+B+CY) mod 256. 3 = SUBB gives (A−B−CY) mod 256. CY is status bit 7 as it stands in that cycle.
- R2: After an edge with ADD, ADDC or SUBB (and no status write), status bit 7 (CY) is 1 exactly when the operation carried out of bit 7 or, for SUBB, borrowed into it.
- R3: After the same edge, status bit 6 (AC) is 1 exactly when the low nibble produced a carry into bit 4, or a borrow from it for SUBB.
- R4: After the same edge, status bit 2 (OV) is 1 exactly when the two's-complement result lies outside −128..127.
- R5: Status bit 0 (P) equals the XOR of all accumulator bits in the same cycle. It follows `acc_i` with no clock and cannot be written.
- R6: Op 4 sets CY and op 5 clears CY at the next edge, and no other status bit changes. Op 0 (and the unused codes 6 and 7) leave the whole status byte unchanged.
- R7: `rn_addr_o` equals {status bit 4 (RS1), status bit 3 (RS0), `reg_idx_i`}.
- R8: When `psw_we_i` is high, status bits 7..1 load from `psw_wdata_i` at the edge, and the write has priority over any operation in that cycle. Bit 0 of the written data has no effect.
- R9: After reset, status bits 7..1 are 0, so `rn_addr_o` equals `reg_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code (0 idle, 1 ADD, 2 ADDC, 3 SUBB, 4 SETC, 5 CLRC) |
| operand_i | input | 8 | Second operand B |
| acc_i | input | 8 | Accumulator value A |
| psw_we_i | input | 1 | Status byte write strobe |
| psw_wdata_i | input | 8 | Status byte write data |
| reg_idx_i | input | 3 | Working register index |
| result_o | output | 8 | Arithmetic result |
| psw_o | output | 8 | Status byte, bit 0 is live parity |
| rn_addr_o | output | 5 | Bank-relative internal RAM address |

## Verification
The hardest case to reach from the ports is an ADDC or SUBB whose outcome depends on a stored carry that an earlier operation left behind. This matters most when the carry-in alone tips the nibble or signed boundary, as with 0xFF+0x00+1 or 0x7F−0xFF−1. The stimulus sets the carry and bank bits through the write port one cycle before each vector. The result is then checked in the operation cycle and the flags in the cycle after it. A write and an operation in the same cycle exercise the write's priority.

// File: rtl/psw_alu_pkg.sv
package psw_alu_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_ADD  = 3'd1,
        OP_ADDC = 3'd2,
        OP_SUBB = 3'd3,
        OP_SETC = 3'd4,
        OP_CLRC = 3'd5
    } alu_op_e;

    localparam int unsigned BIT_CY  = 7;
    localparam int unsigned BIT_AC  = 6;
    localparam int unsigned BIT_RS1 = 4;
    localparam int unsigned BIT_RS0 = 3;
    localparam int unsigned BIT_OV  = 2;
    localparam int unsigned BIT_P   = 0;

endpackage

// File: rtl/psw_addsub.sv
module psw_addsub
    import psw_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o
);
    localparam int unsigned NIB_W = DATA_W / 2;

    logic              use_cin;
    logic              is_sub;
    logic [DATA_W:0]   full_w;
    logic [NIB_W:0]    low_w;
    logic [DATA_W-1:0] top_w;

    always_comb begin
        is_sub  = (op_i == OP_SUBB);
        use_cin = (op_i == OP_ADDC) || (op_i == OP_SUBB);
        if (is_sub) begin
            full_w = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, use_cin & cy_i};
            low_w  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]}
                   - {{NIB_W{1'b0}}, use_cin & cy_i};
            top_w  = {1'b0, a_i[DATA_W-2:0]} - {1'b0, b_i[DATA_W-2:0]}
                   - {{(DATA_W-1){1'b0}}, use_cin & cy_i};
        end else begin
            full_w = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, use_cin & cy_i};
            low_w  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, use_cin & cy_i};
            top_w  = {1'b0, a_i[DATA_W-2:0]} + {1'b0, b_i[DATA_W-2:0]}
                   + {{(DATA_W-1){1'b0}}, use_cin & cy_i};
        end
        res_o = full_w[DATA_W-1:0];
        cy_o  = full_w[DATA_W];
        ac_o  = low_w[NIB_W];
        ov_o  = full_w[DATA_W] ^ top_w[DATA_W-1];
    end

endmodule

// File: rtl/psw_state.sv
module psw_state
    import psw_alu_pkg::*;
#(
    parameter int unsigned PSW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic             we_i,
    input  logic [PSW_W-1:0] wdata_i,
    input  logic             cy_new_i,
    input  logic             ac_new_i,
    input  logic             ov_new_i,
    output logic [PSW_W-1:1] psw_q_o
);
    logic [PSW_W-1:1] psw_q;
    logic [PSW_W-1:1] psw_d;
    alu_op_e          op_e;

    always_comb begin
        op_e  = alu_op_e'(op_i);
        psw_d = psw_q;
        if (we_i) begin
            psw_d = wdata_i[PSW_W-1:1];
        end else begin
            unique case (op_e)
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    psw_d[BIT_CY] = cy_new_i;
                    psw_d[BIT_AC] = ac_new_i;
                    psw_d[BIT_OV] = ov_new_i;
                end
                OP_SETC: psw_d[BIT_CY] = 1'b1;
                OP_CLRC: psw_d[BIT_CY] = 1'b0;
                default: psw_d = psw_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psw_q <= '0;
        else        psw_q <= psw_d;
    end

    assign psw_q_o = psw_q;

    // R8: a write loads bits 7..1 regardless of the operation
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> psw_q == $past(wdata_i[PSW_W-1:1]));
    // R6: set and clear touch only the carry
    a_r6_setc: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && op_i == 3'd4) |=> psw_q[BIT_CY] && $stable(psw_q[BIT_CY-1:1]));
    a_r6_clrc: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && op_i == 3'd5) |=> !psw_q[BIT_CY] && $stable(psw_q[BIT_CY-1:1]));
    // R6: idle holds the byte
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && op_i == 3'd0) |=> $stable(psw_q));

endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned BANK_W = 2
) (
    input  logic [BANK_W-1:0]       bank_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [BANK_W+IDX_W-1:0] addr_o
);
    assign addr_o = {bank_i, idx_i};
endmodule

// File: rtl/psw_alu_core.sv
module psw_alu_core
    import psw_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              psw_we_i,
    input  logic [7:0]        psw_wdata_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        psw_o,
    output logic [IDX_W+1:0]  rn_addr_o
);
    localparam int unsigned PSW_W  = 8;
    localparam int unsigned BANK_W = 2;

    logic [PSW_W-1:1] psw_q;
    logic             cy_new, ac_new, ov_new;
    logic             parity;

    psw_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op_i  (op_i),
        .a_i   (acc_i),
        .b_i   (operand_i),
        .cy_i  (psw_q[BIT_CY]),
        .res_o (result_o),
        .cy_o  (cy_new),
        .ac_o  (ac_new),
        .ov_o  (ov_new)
    );

    psw_state #(.PSW_W(PSW_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .we_i     (psw_we_i),
        .wdata_i  (psw_wdata_i),
        .cy_new_i (cy_new),
        .ac_new_i (ac_new),
        .ov_new_i (ov_new),
        .psw_q_o  (psw_q)
    );

    psw_bank_map #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_bank (
        .bank_i (psw_q[BIT_RS1:BIT_RS0]),
        .idx_i  (reg_idx_i),
        .addr_o (rn_addr_o)
    );

    assign parity = ^acc_i;
    assign psw_o  = {psw_q, parity};

    // R2: two set sign bits always carry out on ADD
    a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!psw_we_i && op_i == 3'd1 && acc_i[DATA_W-1] && operand_i[DATA_W-1])
        |=> psw_o[BIT_CY]);
    // R4: like signs in, different sign out means overflow
    a_r4_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!psw_we_i && op_i == 3'd1 && acc_i[DATA_W-1] == operand_i[DATA_W-1]
         && result_o[DATA_W-1] != acc_i[DATA_W-1]) |=> psw_o[BIT_OV]);
    // R7: bank address follows the stored select bits
    a_r7_bank_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rn_addr_o[IDX_W+1:IDX_W] == psw_o[BIT_RS1:BIT_RS0]);

endmodule

// File: tb/psw_alu_core_tb.sv
module psw_alu_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] operand_i = '0;
    logic [7:0] acc_i = '0;
    logic       psw_we_i = 1'b0;
    logic [7:0] psw_wdata_i = '0;
    logic [2:0] reg_idx_i = '0;
    logic [7:0] result_o;
    logic [7:0] psw_o;
    logic [4:0] rn_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    psw_alu_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
        .acc_i(acc_i), .psw_we_i(psw_we_i), .psw_wdata_i(psw_wdata_i),
        .reg_idx_i(reg_idx_i), .result_o(result_o), .psw_o(psw_o),
        .rn_addr_o(rn_addr_o)
    );

    // stimulus: {op, A, B, stored carry}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {3'd1, 8'h3A, 8'hC6, 1'b0}, {3'd1, 8'h7F, 8'h01, 1'b0},
        {3'd1, 8'h80, 8'h80, 1'b0}, {3'd1, 8'h0F, 8'h01, 1'b1},
        {3'd2, 8'hFF, 8'h00, 1'b1}, {3'd2, 8'h12, 8'h34, 1'b1},
        {3'd2, 8'h7F, 8'h00, 1'b1}, {3'd3, 8'h10, 8'h01, 1'b0},
        {3'd3, 8'h00, 8'h01, 1'b0}, {3'd3, 8'h80, 8'h01, 1'b0},
        {3'd3, 8'h7F, 8'hFF, 1'b1}, {3'd3, 8'h05, 8'h05, 1'b1},
        {3'd3, 8'h20, 8'h10, 1'b1}, {3'd1, 8'h00, 8'h00, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] model(input logic [2:0] op, input int a,
                                          input int b, input int cyin);
        int c, r, sr, sa, sb, lo;
        logic cy, ac, ov;
        c  = (op == 3'd2 || op == 3'd3) ? cyin : 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        if (op == 3'd3) begin
            r = a - b - c; lo = (a % 16) - (b % 16) - c; sr = sa - sb - c;
            cy = (r < 0); ac = (lo < 0);
        end else begin
            r = a + b + c; lo = (a % 16) + (b % 16) + c; sr = sa + sb + c;
            cy = (r > 255); ac = (lo > 15);
        end
        ov = (sr < -128) || (sr > 127);
        model = {r[7:0], cy, ac, ov};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [10:0] e;
        repeat (2) @(negedge clk);
        reg_idx_i = 3'd5;
        #1;
        check("R9 reset status", int'(psw_o[7:1]), 0);
        check("R9 reset addr", int'(rn_addr_o), 5);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op; logic [7:0] a, b; logic cy;
            {op, a, b, cy} = VEC[i];
            @(negedge clk);
            psw_we_i = 1'b1;
            psw_wdata_i = {cy, 1'b0, i[0], i[2:1], 3'b000};
            @(negedge clk);
            psw_we_i = 1'b0; op_i = op; acc_i = a; operand_i = b;
            e = model(op, int'(a), int'(b), int'(cy));
            #1;
            check("R1 result", int'(result_o), int'(e[10:3]));
            @(negedge clk);
            op_i = 3'd0;
            #1;
            check("R2 carry", int'(psw_o[7]), int'(e[2]));
            check("R3 aux carry", int'(psw_o[6]), int'(e[1]));
            check("R4 overflow", int'(psw_o[2]), int'(e[0]));
            check("R6 other bits held", int'(psw_o[5:3]), int'({i[0], i[2:1]}));
        end

        // R5 parity: live, and write of bit 0 ignored
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = 8'(k * 37 + 1);
            @(negedge clk);
            psw_we_i = 1'b1; psw_wdata_i = 8'h01; acc_i = v;
            #1;
            check("R5 parity live", int'(psw_o[0]), $countones(v) % 2);
            @(negedge clk);
            psw_we_i = 1'b0;
            #1;
            check("R5 parity not writable", int'(psw_o[0]), $countones(v) % 2);
        end

        // R6 set / clear carry, idle hold
        @(negedge clk); psw_we_i = 1'b1; psw_wdata_i = 8'h26;
        @(negedge clk); psw_we_i = 1'b0; op_i = 3'd4;
        @(negedge clk); op_i = 3'd0; #1;
        check("R6 setc", int'(psw_o[7:1]), int'(8'hA6 >> 1));
        op_i = 3'd5;
        @(negedge clk); op_i = 3'd7; #1;
        check("R6 clrc", int'(psw_o[7:1]), int'(8'h26 >> 1));
        @(negedge clk); op_i = 3'd0; #1;
        check("R6 unused code holds", int'(psw_o[7:1]), int'(8'h26 >> 1));

        // R8 write beats an arithmetic op in the same cycle
        @(negedge clk);
        op_i = 3'd1; acc_i = 8'hFF; operand_i = 8'hFF;
        psw_we_i = 1'b1; psw_wdata_i = 8'h10;
        @(negedge clk); psw_we_i = 1'b0; op_i = 3'd0; #1;
        check("R8 write priority", int'(psw_o[7:1]), int'(8'h10 >> 1));

        // R7 bank mapping
        for (int rs = 0; rs < 4; rs++) begin
            @(negedge clk);
            psw_we_i = 1'b1; psw_wdata_i = 8'(rs << 3);
            @(negedge clk);
            psw_we_i = 1'b0;
            for (int ix = 0; ix < 8; ix += 3) begin
                reg_idx_i = 3'(ix);
                #1;
                check("R7 bank address", int'(rn_addr_o), rs * 8 + ix);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule